// File: doc/BRIEF.md
# Turbo Fast-RAM Overlay Controller

This block gives the memory path an optional fast mode. While fast mode is on, every CPU access whose address falls in the bottom 8 KB (0x0000 to 0x1FFF) goes to an on-chip RAM instead of external DRAM. Such an access asks the clock generator for an uncontended CPU cycle, so video fetches never stall it. Accesses at 0x2000 and above go to DRAM as usual and keep normal contention.

Fast mode switches on when one keyboard sample shows Ctrl, Caps Lock and the 2 key all held down. It switches on once for each press of that chord, not repeatedly while the keys stay held. Fast mode switches off when the break input is asserted, and it is off after reset. The on-chip RAM keeps its contents while fast mode is off. Writes made while fast mode is off go to DRAM and leave the on-chip RAM unchanged.

Top module: `turbo_overlay`

## Requirements
- R1: After a synchronous active-low reset, `turbo_on`, `fast_sel`, `fast_clk_req` and `fast_rvalid` are all 0.
- R2: If `key_sample` is high at a clock edge while `key_ctrl`, `key_caps` and `key_two` are all 1, and `brk` is low, `turbo_on` is 1 from that edge onward.
- R3: A sample with only some of the three keys down does not enable fast mode. Key flags that are all 1 while `key_sample` is low also do not enable it.
- R4: Fast mode is enabled only on a sample where the chord is down and the previous sample did not show the full chord. Holding the chord through a break does not re-enable fast mode. Releasing the keys and pressing the chord again does re-enable it.
- R5: `brk` high at a clock edge clears `turbo_on` at that edge. It takes priority over a chord sample at the same edge.
- R6: While `turbo_on` is 1, a valid access with address below 0x2000 asserts `fast_sel` and `fast_clk_req` in the same cycle, and `dram_req` stays 0.
- R7: A valid access with address 0x2000 or higher asserts `dram_req` and never asserts `fast_sel`, whether fast mode is on or off.
- R8: While `turbo_on` is 0, every valid access asserts `dram_req` and leaves `fast_sel` at 0.
- R9: A fast write stores its byte in the on-chip RAM. A fast read raises `fast_rvalid` exactly one clock later, with `fast_rdata` equal to the last byte written at that address. No other access raises `fast_rvalid`.
- R10: On-chip RAM contents survive fast mode being turned off and on again. A write at an overlay address made while fast mode is off does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | A CPU access is presented this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| key_sample | input | 1 | Keyboard flags below hold a fresh sample |
| key_ctrl | input | 1 | Ctrl key down |
| key_caps | input | 1 | Caps Lock key down |
| key_two | input | 1 | The 2 key down |
| brk | input | 1 | Break pressed |
| turbo_on | output | 1 | Fast mode active |
| fast_sel | output | 1 | Current access is served by on-chip RAM |
| fast_clk_req | output | 1 | Request an uncontended CPU cycle |
| dram_req | output | 1 | Current access goes to external DRAM |
| fast_rdata | output | 8 | Read data from on-chip RAM |
| fast_rvalid | output | 1 | `fast_rdata` holds the result of the previous cycle's fast read |

## Verification
Each result has a fixed due time. `fast_sel`, `fast_clk_req` and `dram_req` are combinational, so the bench checks them in the same cycle as the access, just after driving it on the falling edge. `turbo_on` changes at the first rising edge that sees the sample or the break, and the bench checks it at the next falling edge. Fast read data and `fast_rvalid` come one rising edge after the read, so the driver tags each expected byte with the cycle in which it is due. The monitor flags a valid pulse with no item due, and also an item due with no valid pulse.

// File: rtl/turbo_ovl_pkg.sv
// Package: shared types for the turbo fast-RAM overlay.
// Assumes: nothing beyond IEEE 1800-2017.
package turbo_ovl_pkg;

    // Destination of the access presented this cycle
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_DRAM = 2'd1,
        ROUTE_FAST = 2'd2
    } route_e;

endpackage

// File: rtl/tov_mode_ctl.sv
// Module: tov_mode_ctl
// Holds the fast-mode flag. Sets it on the rising edge of a fully pressed
// key chord seen on keyboard samples; clears it on break (break wins).
// Assumes: key flags are only meaningful when key_sample is high.
module tov_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic key_sample,
    input  logic key_ctrl,
    input  logic key_caps,
    input  logic key_two,
    input  logic brk,
    output logic turbo_on
);

    logic chord_now;
    logic chord_prev;
    logic chord_edge;

    // Full chord present on the current flags
    always_comb chord_now = key_ctrl & key_caps & key_two;

    // New press: chord on this sample, absent on the previous one
    always_comb chord_edge = key_sample & chord_now & ~chord_prev;

    // Remember chord state of the last keyboard sample
    always_ff @(posedge clk) begin
        if (!rst_n)          chord_prev <= 1'b0;
        else if (key_sample) chord_prev <= chord_now;
    end

    // Fast-mode flag: break clears, chord edge sets
    always_ff @(posedge clk) begin
        if (!rst_n)          turbo_on <= 1'b0;
        else if (brk)        turbo_on <= 1'b0;
        else if (chord_edge) turbo_on <= 1'b1;
    end

    // R5: break clears the mode on the next cycle
    a_r5_brk_clears: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !turbo_on);

    // R2: a new chord press without break enables the mode
    a_r2_chord_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (key_sample && key_ctrl && key_caps && key_two && !chord_prev && !brk) |=> turbo_on);

    // R3: without a sample and without break the mode does not move
    a_r3_no_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_sample && !brk) |=> $stable(turbo_on));

endmodule

// File: rtl/tov_decode.sv
// Module: tov_decode
// Routes each CPU access to on-chip RAM or DRAM and extracts the overlay
// byte index. Purely combinational.
// Assumes: ADDR_W > OVL_ADDR_W; the overlay starts at address zero.
module tov_decode
    import turbo_ovl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OVL_ADDR_W = 13
) (
    input  logic                  cpu_valid,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  turbo_on,
    output route_e                route,
    output logic [OVL_ADDR_W-1:0] ovl_index
);

    localparam int HI_W = ADDR_W - OVL_ADDR_W;

    logic in_window;

    // Address lies inside the low overlay window
    always_comb in_window = (cpu_addr[ADDR_W-1:OVL_ADDR_W] == {HI_W{1'b0}});

    // Byte index inside the overlay
    always_comb ovl_index = cpu_addr[OVL_ADDR_W-1:0];

    // Pick the destination of this access
    always_comb begin
        if (!cpu_valid)                route = ROUTE_IDLE;
        else if (turbo_on && in_window) route = ROUTE_FAST;
        else                           route = ROUTE_DRAM;
    end

endmodule

// File: rtl/tov_fast_ram.sv
// Module: tov_fast_ram
// Single-port byte-addressed RAM built from LANES byte-wide banks, so the
// deepest array is SIZE/LANES entries. One-cycle registered read.
// Assumes: LANES is a power of two >= 2; rd_en and wr_en never both high.
module tov_fast_ram #(
    parameter int OVL_ADDR_W = 13,
    parameter int DATA_W     = 8,
    parameter int LANES      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [OVL_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rvalid
);

    localparam int LANE_W  = $clog2(LANES);
    localparam int WORD_AW = OVL_ADDR_W - LANE_W;
    localparam int DEPTH   = 1 << WORD_AW;

    logic [LANE_W-1:0]  lane;
    logic [WORD_AW-1:0] word;
    logic [LANE_W-1:0]  lane_q;
    logic [DATA_W-1:0]  lane_rd [LANES];

    // Split byte index into bank select and row
    always_comb begin
        lane = addr[LANE_W-1:0];
        word = addr[OVL_ADDR_W-1:LANE_W];
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_bank
            logic [DATA_W-1:0] bank [DEPTH];

            // Write the byte into this bank when it is selected
            always_ff @(posedge clk) begin
                if (wr_en && lane == LANE_W'(g)) bank[word] <= wdata;
            end

            // Registered read of this bank's row
            always_ff @(posedge clk) begin
                if (rd_en) lane_rd[g] <= bank[word];
            end
        end
    endgenerate

    // Track which bank the pending read came from and flag its result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            rvalid <= 1'b0;
        end else begin
            if (rd_en) lane_q <= lane;
            rvalid <= rd_en;
        end
    end

    // Select the byte of the bank that was read
    always_comb rdata = lane_rd[lane_q];

    // R9: a read yields a valid result exactly one cycle later
    a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R9: no result without a read in the previous cycle
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

endmodule

// File: rtl/turbo_overlay.sv
// Module: turbo_overlay (top)
// Fast-RAM overlay controller: key-chord enable, break exit, low-window
// routing to on-chip RAM with an uncontended-clock request.
// Assumes: one CPU access per cycle with cpu_valid; DRAM and the keyboard
// scanner live outside.
module turbo_overlay
    import turbo_ovl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int OVL_ADDR_W = 13,
    parameter int LANES      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              key_sample,
    input  logic              key_ctrl,
    input  logic              key_caps,
    input  logic              key_two,
    input  logic              brk,
    output logic              turbo_on,
    output logic              fast_sel,
    output logic              fast_clk_req,
    output logic              dram_req,
    output logic [DATA_W-1:0] fast_rdata,
    output logic              fast_rvalid
);

    route_e                route;
    logic [OVL_ADDR_W-1:0] ovl_index;
    logic                  ram_wr;
    logic                  ram_rd;

    tov_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_sample (key_sample),
        .key_ctrl   (key_ctrl),
        .key_caps   (key_caps),
        .key_two    (key_two),
        .brk        (brk),
        .turbo_on   (turbo_on)
    );

    tov_decode #(
        .ADDR_W     (ADDR_W),
        .OVL_ADDR_W (OVL_ADDR_W)
    ) u_dec (
        .cpu_valid (cpu_valid),
        .cpu_addr  (cpu_addr),
        .turbo_on  (turbo_on),
        .route     (route),
        .ovl_index (ovl_index)
    );

    // Drive routing outputs and RAM strobes from the decoded route
    always_comb begin
        fast_sel     = (route == ROUTE_FAST);
        fast_clk_req = (route == ROUTE_FAST);
        dram_req     = (route == ROUTE_DRAM);
        ram_wr       = (route == ROUTE_FAST) &  cpu_we;
        ram_rd       = (route == ROUTE_FAST) & ~cpu_we;
    end

    tov_fast_ram #(
        .OVL_ADDR_W (OVL_ADDR_W),
        .DATA_W     (DATA_W),
        .LANES      (LANES)
    ) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ram_wr),
        .rd_en  (ram_rd),
        .addr   (ovl_index),
        .wdata  (cpu_wdata),
        .rdata  (fast_rdata),
        .rvalid (fast_rvalid)
    );

    // R8: with fast mode off nothing is served from on-chip RAM
    a_r8_off_no_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !turbo_on |-> !fast_sel);

    // R7: addresses above the window always go to DRAM
    a_r7_high_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_addr >= ADDR_W'(1 << OVL_ADDR_W)) |-> (dram_req && !fast_sel));

    // R6: a valid access goes to exactly one destination
    a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> $onehot({fast_sel, dram_req}));

    // R6: the fast-clock request appears only with a fast access
    a_r6_clk_req_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clk_req |-> (cpu_valid && turbo_on));

endmodule

// File: tb/turbo_overlay_tb.sv
module turbo_overlay_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_we;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        key_sample, key_ctrl, key_caps, key_two, brk;
    logic        turbo_on, fast_sel, fast_clk_req, dram_req;
    logic [7:0]  fast_rdata;
    logic        fast_rvalid;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { int due; logic [7:0] data; } exp_t;
    exp_t        sb_q[$];
    logic [7:0]  model[int];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    turbo_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .key_sample(key_sample),
        .key_ctrl(key_ctrl), .key_caps(key_caps), .key_two(key_two), .brk(brk),
        .turbo_on(turbo_on), .fast_sel(fast_sel), .fast_clk_req(fast_clk_req),
        .dram_req(dram_req), .fast_rdata(fast_rdata), .fast_rvalid(fast_rvalid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected read results at their due cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R9", "fast_rvalid on due read", int'(fast_rvalid), 1);
                chk("R9", "fast_rdata", int'(fast_rdata), int'(e.data));
            end else if (fast_rvalid) begin
                chk("R9", "fast_rvalid with no read due", 1, 0);
            end
        end
    end

    // Driver: one keyboard sample
    task automatic press(input logic c, input logic k, input logic t, input logic b);
        @(negedge clk);
        key_ctrl = c; key_caps = k; key_two = t; key_sample = 1'b1; brk = b;
        @(negedge clk);
        key_sample = 1'b0; brk = 1'b0;
    endtask

    // Driver: one CPU access with route checks; pushes expected read data
    task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d,
                          input string req, input logic exp_fast);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        chk(req, "fast_sel", int'(fast_sel), int'(exp_fast));
        chk(req, "fast_clk_req", int'(fast_clk_req), int'(exp_fast));
        chk(req, "dram_req", int'(dram_req), int'(!exp_fast));
        if (exp_fast) begin
            if (we) model[int'(a)] = d;
            else begin
                exp_t e;
                e.due = cyc + 1;
                e.data = model.exists(int'(a)) ? model[int'(a)] : 8'h00;
                sb_q.push_back(e);
            end
        end
        @(posedge clk); #1;
        cpu_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        mismatched++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cpu_valid = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
        key_sample = 0; key_ctrl = 0; key_caps = 0; key_two = 0; brk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "turbo_on", int'(turbo_on), 0);
        chk("R1", "fast_sel", int'(fast_sel), 0);
        chk("R1", "fast_clk_req", int'(fast_clk_req), 0);
        chk("R1", "fast_rvalid", int'(fast_rvalid), 0);

        // R8: turbo off, low addresses go to DRAM, no read result
        access(16'h0010, 1'b1, 8'h11, "R8", 1'b0);
        access(16'h0010, 1'b0, 8'h00, "R8", 1'b0);

        // R3: partial chords and unsampled full chord do nothing
        press(1, 1, 0, 0);
        chk("R3", "turbo_on after ctrl+caps", int'(turbo_on), 0);
        press(0, 1, 1, 0);
        chk("R3", "turbo_on after caps+2", int'(turbo_on), 0);
        @(negedge clk);
        key_ctrl = 1; key_caps = 1; key_two = 1;
        repeat (2) @(negedge clk);
        chk("R3", "turbo_on with flags but no sample", int'(turbo_on), 0);
        key_ctrl = 0; key_caps = 0; key_two = 0;

        // R2: full chord on one sample enables
        press(1, 1, 1, 0);
        chk("R2", "turbo_on after chord", int'(turbo_on), 1);
        press(0, 0, 0, 0);

        // R6 / R9: overlay writes and reads at the window top
        access(16'h1FFF, 1'b1, 8'hA5, "R6", 1'b1);
        access(16'h1FFF, 1'b0, 8'h00, "R9", 1'b1);
        // R7: first address above the window stays on DRAM
        access(16'h2000, 1'b1, 8'h5A, "R7", 1'b0);
        access(16'h2000, 1'b0, 8'h00, "R7", 1'b0);
        access(16'hFFFF, 1'b0, 8'h00, "R7", 1'b0);
        // R9: bytes across all banks, read back in reverse
        for (int i = 0; i < 8; i++)
            access(16'(i), 1'b1, 8'(8'h30 + i * 7), "R9", 1'b1);
        for (int i = 7; i >= 0; i--)
            access(16'(i), 1'b0, 8'h00, "R9", 1'b1);
        access(16'h1FFF, 1'b0, 8'h00, "R9", 1'b1);

        // R5: break wins over a chord sample at the same edge
        press(1, 1, 1, 1);
        chk("R5", "turbo_on after break with chord", int'(turbo_on), 0);
        // R4: still-held chord does not re-enable
        press(1, 1, 1, 0);
        chk("R4", "turbo_on with chord held", int'(turbo_on), 0);
        press(0, 0, 0, 0);
        press(1, 1, 1, 0);
        chk("R4", "turbo_on after re-press", int'(turbo_on), 1);
        press(0, 0, 0, 0);

        // R5: plain break clears
        press(0, 0, 0, 1);
        chk("R5", "turbo_on after break", int'(turbo_on), 0);

        // R10: write with turbo off must not reach on-chip RAM
        access(16'h0001, 1'b1, 8'hEE, "R10", 1'b0);
        press(1, 1, 1, 0);
        chk("R10", "turbo_on re-enabled", int'(turbo_on), 1);
        press(0, 0, 0, 0);
        access(16'h0001, 1'b0, 8'h00, "R10", 1'b1);
        access(16'h1FFF, 1'b0, 8'h00, "R10", 1'b1);

        repeat (3) @(negedge clk);
        chk("R9", "no pending reads left", sb_q.size(), 0);
        finish_run();
    end

endmodule